// File: doc/BRIEF.md
# I2C Command Buffer Slave

This block is an I2C slave that gathers command bytes from a bus master into an on-chip first-in first-out buffer, and returns a one-byte status word whenever the master reads. It watches the bus for START and STOP conditions and compares the first byte after a START with a fixed 7-bit address. It acknowledges every byte it takes. A local consumer drains the buffer through a simple pop port. The consumer splits the bytes into one-byte or two-byte commands. This block does not parse them, but it keeps their order exactly, so the leading byte of a two-byte command always comes out first.

The master never selects a register. A write session streams bytes straight into the buffer. A read session gets the status byte at once. The top bit of that byte tells the master whether at least two more bytes will fit, so it can send a complete two-byte command safely. A sticky flag reports a byte that was refused because the buffer was full, and the next STOP clears it. The bus pins are sampled through two-flop synchronizers in the system clock domain. That clock must run at least eight times faster than SCL.

Top module: `i2c_cmd_slave`

## Requirements
- R1: After a START, the slave acknowledges (drives SDA low through the ninth SCL clock) an address byte whose upper seven bits, MSB first, equal SLAVE_ADDR. For any other address it does not acknowledge, and it leaves SDA released for every later bit and byte until the next START.
- R2: When the eighth address bit is 0 (write), each following 8-bit byte, sampled MSB first on SCL rising edges, is acknowledged and stored in the buffer. This holds for bytes arriving while the buffer holds fewer than DEPTH entries.
- R3: The buffer delivers bytes in arrival order. cmd_valid_o is high exactly when the buffer is not empty, and cmd_data_o shows the oldest byte. A one-cycle pop_i removes that byte. pop_i while the buffer is empty changes nothing.
- R4: A data byte that arrives while the buffer holds DEPTH bytes is not acknowledged and is not stored, and the overflow flag (status bit 6) becomes 1.
- R5: When the eighth address bit is 1 (read), the slave sends the status byte, MSB first, starting right after the address acknowledge. Bit 7 is ready, bit 6 is overflow, and bits 5:0 are stat_i. SDA changes only while SCL is low.
- R6: The ready bit is 1 exactly when DEPTH minus the number of stored bytes is at least 2.
- R7: During a read, a master acknowledge after a status byte makes the slave send the status byte again. A master NACK makes it release SDA until the next START or STOP.
- R8: A STOP clears the overflow flag and returns the slave to idle. A repeated START in any state begins a new address phase.
- R9: After reset, SDA is released (sda_oe_o = 0), the buffer is empty (cmd_valid_o = 0), and the overflow flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain), 0 releases it |
| pop_i | input | 1 | Remove the oldest buffered byte |
| cmd_valid_o | output | 1 | Buffer holds at least one byte |
| cmd_data_o | output | 8 | Oldest buffered byte |
| stat_i | input | 6 | Consumer status, placed in status bits 5:0 |

## Verification
The bench builds the slave with DEPTH = 8 and SLAVE_ADDR = 7'h52. The small depth lets one write session reach every fill level: the point where ready drops from 1 to 0 at two free slots, the last accepted byte, and the first refused byte that raises the overflow flag. The non-default address lets the bench probe a mismatch that differs only in the last address bit. A queue model of the buffer is compared with the pop port on every clock, and status bytes read at each interesting fill level are compared with values derived from the model.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam int STAT_W = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } slv_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_pipe_q;
  logic [STAGES-1:0] sda_pipe_q;
  logic              scl_prev_q;
  logic              sda_prev_q;

  // Idle bus is high, so all stages reset to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
      scl_prev_q <= scl_pipe_q[STAGES-1];
      sda_prev_q <= sda_pipe_q[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe_q[STAGES-1];
  assign sda_o      = sda_pipe_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev_q;
  assign scl_fall_o = ~scl_o & scl_prev_q;
  // SDA moving while SCL stays high marks START (falling) or STOP (rising).
  assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
  assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;

endmodule

// File: rtl/cmd_fifo.sv
module cmd_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             ready_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    count_q, count_d;
  logic             push_en;
  logic             pop_en;

  assign push_en = push_i & (count_q != CW'(DEPTH));
  assign pop_en  = pop_i & (count_q != '0);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (push_en) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (pop_en)  rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    if (push_en && !pop_en)      count_d = count_q + 1'b1;
    else if (pop_en && !push_en) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  // Storage has no reset; only written entries are ever read.
  always_ff @(posedge clk) begin
    if (push_en) mem_q[wr_ptr_q] <= push_data_i;
  end

  assign valid_o = (count_q != '0);
  assign data_o  = mem_q[rd_ptr_q];
  assign full_o  = (count_q == CW'(DEPTH));
  assign ready_o = (CW'(DEPTH) - count_q) >= CW'(2);

  // The controller must never offer a byte into a full buffer.
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (count_q < CW'(DEPTH)));

  // Popping an empty buffer leaves it empty.
  assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && count_q == '0) |=> (count_q == '0));

  // A lone push grows the occupancy by exactly one.
  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && count_q < CW'(DEPTH)) |=> (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl_i,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              fifo_full_i,
  input  logic              fifo_ready_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              push_o,
  output logic [BYTE_W-1:0] push_data_o,
  output logic              sda_oe_o
);

  slv_state_e        state_q, state_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              rw_q, rw_d;
  logic              ack_q, ack_d;
  logic              mack_q, mack_d;
  logic              ovf_q, ovf_d;
  logic [BYTE_W-1:0] status_byte;
  logic              byte_done;

  assign status_byte = {fifo_ready_i, ovf_q, stat_i};
  assign byte_done   = scl_fall_i & (cnt_q == 4'd8);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    rw_d    = rw_q;
    ack_d   = ack_q;
    mack_d  = mack_q;
    ovf_d   = ovf_q;
    push_o  = 1'b0;
    if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      ovf_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise_i) begin
            rx_d  = {rx_q[BYTE_W-2:0], sda_lvl_i};
            cnt_d = cnt_q + 1'b1;
          end else if (byte_done) begin
            rw_d    = rx_q[0];
            state_d = (rx_q[7:1] == SLAVE_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            cnt_d = '0;
            if (rw_q) begin
              state_d = ST_RD_BYTE;
              tx_d    = status_byte;
            end else begin
              state_d = ST_WR_BYTE;
            end
          end
        end
        ST_WR_BYTE: begin
          if (scl_rise_i) begin
            rx_d  = {rx_q[BYTE_W-2:0], sda_lvl_i};
            cnt_d = cnt_q + 1'b1;
          end else if (byte_done) begin
            state_d = ST_WR_ACK;
            ack_d   = ~fifo_full_i;
            push_o  = ~fifo_full_i;
            if (fifo_full_i) ovf_d = 1'b1;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall_i) begin
            state_d = ST_WR_BYTE;
            cnt_d   = '0;
          end
        end
        ST_RD_BYTE: begin
          if (scl_fall_i) begin
            tx_d  = {tx_q[BYTE_W-2:0], 1'b1};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == 4'd7) state_d = ST_RD_ACK;
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            mack_d = ~sda_lvl_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              state_d = ST_RD_BYTE;
              tx_d    = status_byte;
              cnt_d   = '0;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '1;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
      mack_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      rw_q    <= rw_d;
      ack_q   <= ack_d;
      mack_q  <= mack_d;
      ovf_q   <= ovf_d;
    end
  end

  assign push_data_o = rx_q;

  always_comb begin
    unique case (state_q)
      ST_ADDR_ACK: sda_oe_o = 1'b1;
      ST_WR_ACK:   sda_oe_o = ack_q;
      ST_RD_BYTE:  sda_oe_o = ~tx_q[BYTE_W-1];
      default:     sda_oe_o = 1'b0;
    endcase
  end

  // SDA output moves only while SCL is low, unless a START/STOP just occurred.
  assert_sda_moves_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> (!scl_lvl_i || $past(start_i) || $past(stop_i)));

  // A foreign address leads to the ignore state.
  assert_foreign_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && byte_done && !start_i && !stop_i && rx_q[7:1] != SLAVE_ADDR)
      |=> (state_q == ST_IGNORE && !sda_oe_o));

  // STOP returns to idle with SDA released and the overflow flag cleared.
  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> (state_q == ST_IDLE && !ovf_q && !sda_oe_o));

  // A refused byte always raises the overflow flag.
  assert_refuse_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR_BYTE && byte_done && fifo_full_i && !start_i && !stop_i)
      |=> (ovf_q && !sda_oe_o));

endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave
  import i2c_cmd_pkg::*;
#(
  parameter int         DEPTH       = 32,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] SLAVE_ADDR  = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              pop_i,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_data_o,
  input  logic [STAT_W-1:0] stat_i
);

  logic rst_meta_q, rst_sync_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic push, fifo_full, fifo_ready;
  logic [BYTE_W-1:0] push_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_lvl),
    .sda_o      (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2c_slave_ctrl #(.SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .scl_lvl_i    (scl_lvl),
    .sda_lvl_i    (sda_lvl),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .start_i      (bus_start),
    .stop_i       (bus_stop),
    .fifo_full_i  (fifo_full),
    .fifo_ready_i (fifo_ready),
    .stat_i       (stat_i),
    .push_o       (push),
    .push_data_o  (push_data),
    .sda_oe_o     (sda_oe_o)
  );

  cmd_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop_i),
    .valid_o     (cmd_valid_o),
    .data_o      (cmd_data_o),
    .full_o      (fifo_full),
    .ready_o     (fifo_ready)
  );

endmodule

// File: tb/i2c_cmd_slave_test.sv
module i2c_cmd_slave_test;

  localparam int         DEPTH = 8;
  localparam logic [6:0] ADDR  = 7'h52;
  localparam int         Q     = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic       scl_m, sda_m, pop;
  logic [5:0] stat;
  logic       sda_oe, cmd_valid;
  logic [7:0] cmd_data;
  logic       sda_line;

  assign sda_line = sda_oe ? 1'b0 : sda_m;

  i2c_cmd_slave #(.DEPTH(DEPTH), .SLAVE_ADDR(ADDR)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .pop_i       (pop),
    .cmd_valid_o (cmd_valid),
    .cmd_data_o  (cmd_data),
    .stat_i      (stat)
  );

  int         compared   = 0;
  int         mismatched = 0;
  bit         cmp_en     = 1'b0;
  bit         model_ovf  = 1'b0;
  logic [7:0] q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Reference buffer: pops follow the same posedge the design uses.
  always @(posedge clk) if (rst_n && pop && q.size() > 0) void'(q.pop_front());

  // R3: pop port compared with the model on every clock.
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk(cmd_valid == (q.size() > 0), "R3 valid", cmd_valid, q.size() > 0);
      if (q.size() > 0) chk(cmd_data == q[0], "R3 data", cmd_data, q[0]);
    end
  end

  function automatic logic [7:0] exp_status();
    return {(DEPTH - q.size()) >= 2, model_ovf, stat};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
    model_ovf = 1'b0;
  endtask

  task automatic bit_w(input logic b);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bit_r(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit exp_ack, input string req);
    logic a;
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) cmp_en = 1'b0;
      bit_w(v[i]);
    end
    bit_r(a);
    chk(a == !exp_ack, req, a, !exp_ack);
    cmp_en = 1'b1;
  endtask

  // R2/R4: data byte; acceptance predicted from the model occupancy.
  task automatic write_data(input logic [7:0] v);
    bit fits;
    fits = q.size() < DEPTH;
    send_byte(v, fits, fits ? "R2 data ack" : "R4 full nack");
    if (fits) q.push_back(v);
    else model_ovf = 1'b1;
  endtask

  task automatic read_status(input int reps, input string req);
    logic [7:0] v;
    logic b;
    bus_start();
    send_byte({ADDR, 1'b1}, 1'b1, "R1 read addr ack");
    for (int r = 0; r < reps; r++) begin
      for (int i = 7; i >= 0; i--) begin
        bit_r(b);
        v[i] = b;
      end
      chk(v == exp_status(), req, v, exp_status());
      bit_w((r == reps - 1) ? 1'b1 : 1'b0);
    end
    tick(2);
    chk(sda_oe == 1'b0, "R7 release after nack", sda_oe, 0);
  endtask

  task automatic pop_one();
    chk(cmd_valid && cmd_data == q[0], "R3 pop order", cmd_data, q[0]);
    pop = 1'b1; tick(1);
    pop = 1'b0; tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; pop = 1'b0; stat = 6'h2D;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R9: reset state
    chk(sda_oe == 1'b0, "R9 sda released", sda_oe, 0);
    chk(cmd_valid == 1'b0, "R9 buffer empty", cmd_valid, 0);
    cmp_en = 1'b1;

    // R5/R6/R7: empty buffer, status read twice via master ack then nack
    read_status(2, "R5 R7 status empty");
    bus_stop();

    // R2: short write session, then drain in order
    bus_start();
    send_byte({ADDR, 1'b0}, 1'b1, "R1 write addr ack");
    write_data(8'hA5);
    write_data(8'h3C);
    write_data(8'h81);
    bus_stop();
    tick(4);
    pop_one(); pop_one(); pop_one();
    // R3: pop on empty buffer has no effect
    pop = 1'b1; tick(1); pop = 1'b0; tick(2);
    chk(cmd_valid == 1'b0, "R3 empty pop", cmd_valid, 0);

    // R1: foreign address (last bit differs) and its data are ignored
    bus_start();
    send_byte({ADDR ^ 7'h01, 1'b0}, 1'b0, "R1 foreign addr nack");
    send_byte(8'h00, 1'b0, "R1 ignored byte");
    tick(2);
    chk(cmd_valid == 1'b0, "R1 nothing stored", cmd_valid, 0);
    bus_stop();

    // R6/R4/R8: fill to the ready threshold and beyond, with repeated STARTs
    stat = 6'h12;
    bus_start();
    send_byte({ADDR, 1'b0}, 1'b1, "R1 write addr ack");
    for (int i = 0; i < DEPTH - 2; i++) write_data(8'(i * 17 + 3));
    read_status(1, "R6 two free ready");
    bus_start();
    send_byte({ADDR, 1'b0}, 1'b1, "R8 repeated start ack");
    write_data(8'hE1);
    read_status(1, "R6 one free not ready");
    bus_start();
    send_byte({ADDR, 1'b0}, 1'b1, "R8 repeated start ack");
    write_data(8'hE2);
    write_data(8'hF0);
    write_data(8'hF1);
    read_status(1, "R4 overflow flag");
    bus_stop();
    read_status(1, "R8 stop cleared overflow");
    bus_stop();
    tick(4);
    while (q.size() > 0) pop_one();
    tick(4);
    chk(cmd_valid == 1'b0, "R3 drained", cmd_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule